// File: doc/BRIEF.md
# Receive Line Idle and Character Timeout Timer

This block watches the receive line of a serial port and measures how long it has stayed quiet, counted in bit periods. It is fed a strobe that fires once per bit, in the middle of the bit, together with the line level sampled at that moment. From these it builds two indications. The first is an idle detect, used to decide when the port may sleep. The second is a character timeout, used to raise an interrupt when received data sits in the receive FIFO and nothing more arrives.

Both indications use the same limit, which depends on the programmed character length: four times the word length plus twelve bit periods. The idle detect is reset only by line activity. The timeout counts only while the FIFO holds data. It is reset by line activity or by a read of the receive holding register. The bit strobe, the FIFO and interrupt prioritisation sit outside this block.

Top module: `rxto_idle_timer`

## Requirements
- R1: `idle_detect` goes high on the bit strobe that completes 32 + 4*`word_len` consecutive high samples. The `word_len` code maps 0→5, 1→6, 2→7 and 3→8 bits, giving limits of 32, 36, 40 and 44.
- R2: Both counters change only on cycles where `bit_tick` is 1. A cycle without the strobe leaves both outputs unchanged, apart from the clears in R4 and R5.
- R3: A low `rx_sample` on a cycle with `bit_tick` set clears the idle count. `idle_detect` is 0 from the next cycle.
- R4: The timeout count is held at zero while `fifo_nempty` is 0. `char_timeout` is 0 on the cycle after any cycle with `fifo_nempty` at 0.
- R5: `rhr_read` clears the timeout count. This clear takes priority over a high-sample strobe in the same cycle, and `char_timeout` is 0 on the next cycle.
- R6: `char_timeout` goes high on the strobe that completes 32 + 4*`word_len` consecutive high samples while `fifo_nempty` stays 1 and `rhr_read` stays 0.
- R7: Both counters saturate at their limit and never wrap. An asserted indication stays high through any number of further high-sample strobes.
- R8: While `rst_n` is low, both outputs are 0 and both counts are zero.
- R9: A low `rx_sample` at a strobe also clears the timeout count. `char_timeout` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Mid-bit sample strobe, one cycle wide |
| rx_sample | input | 1 | Receive line level, valid when bit_tick is 1 |
| word_len | input | 2 | Character length code (0..3 → 5..8 bits) |
| fifo_nempty | input | 1 | Receive FIFO holds at least one entry |
| rhr_read | input | 1 | Receive holding register is read this cycle |
| idle_detect | output | 1 | Line has been high for the full limit |
| char_timeout | output | 1 | FIFO data has waited for the full limit |

## Verification
Two things can fall in the same cycle: a high-sample strobe that would advance the timeout, and a holding-register read (or an empty FIFO) that clears it. The bench sets up both conditions in one cycle, first when the count is partway and then when it is one strobe short of the limit. The clear must win, and the idle detect must keep counting through the same strobe. A cycle-level reference model checks every output on every clock. Explicit checks then confirm that `char_timeout` stays low after the collision and needs a full limit of new strobes to rise again.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int unsigned WL_W     = 2;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned SLOPE    = 4;
  localparam int unsigned BASE     = 12;
  localparam int unsigned MAX_SPAN = SLOPE * (MIN_BITS + (1 << WL_W) - 1) + BASE;
  localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);

  typedef enum logic [0:0] {
    CH_SLEEP   = 1'b0,
    CH_TIMEOUT = 1'b1
  } chan_e;
endpackage

// File: rtl/rxto_span_calc.sv
module rxto_span_calc #(
  parameter int unsigned WL_W     = 2,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned SLOPE    = 4,
  parameter int unsigned BASE     = 12
) (
  input  logic [WL_W-1:0]  word_len,
  output logic [CNT_W-1:0] span
);
  localparam int unsigned OFFSET = SLOPE * MIN_BITS + BASE;

  logic [CNT_W-1:0] wl_ext;

  always_comb begin
    wl_ext = CNT_W'(word_len);
    span   = CNT_W'(OFFSET) + CNT_W'(SLOPE) * wl_ext;
  end
endmodule

// File: rtl/rxto_sat_counter.sv
module rxto_sat_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (clr) begin
      count_en = 1'b1;
      count_d  = '0;
    end else if (adv && (count_q < limit)) begin
      count_en = 1'b1;
      count_d  = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign reached = (count_q >= limit);
endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer
  import rxto_pkg::*;
#(
  parameter int unsigned P_WL_W  = WL_W,
  parameter int unsigned P_CNT_W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rx_sample,
  input  logic [P_WL_W-1:0] word_len,
  input  logic              fifo_nempty,
  input  logic              rhr_read,
  output logic              idle_detect,
  output logic              char_timeout
);
  localparam int unsigned NCH = 2;

  logic [P_CNT_W-1:0] span;
  logic               line_active;
  logic [NCH-1:0]     ch_clr;
  logic [NCH-1:0]     ch_adv;
  logic [NCH-1:0]     ch_hit;

  rxto_span_calc #(
    .WL_W    (P_WL_W),
    .CNT_W   (P_CNT_W),
    .MIN_BITS(MIN_BITS),
    .SLOPE   (SLOPE),
    .BASE    (BASE)
  ) u_span (
    .word_len(word_len),
    .span    (span)
  );

  always_comb begin
    line_active        = bit_tick & ~rx_sample;
    ch_clr[CH_SLEEP]   = line_active;
    ch_adv[CH_SLEEP]   = bit_tick;
    ch_clr[CH_TIMEOUT] = line_active | rhr_read | ~fifo_nempty;
    ch_adv[CH_TIMEOUT] = bit_tick & fifo_nempty;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    rxto_sat_counter #(
      .CNT_W(P_CNT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ch_clr[g]),
      .adv    (ch_adv[g]),
      .limit  (span),
      .reached(ch_hit[g])
    );
  end

  assign idle_detect  = ch_hit[CH_SLEEP];
  assign char_timeout = ch_hit[CH_TIMEOUT];
endmodule

// File: rtl/rxto_idle_timer_chk.sv
module rxto_idle_timer_chk #(
  parameter int unsigned P_WL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              rx_sample,
  input logic [P_WL_W-1:0] word_len,
  input logic              fifo_nempty,
  input logic              rhr_read,
  input logic              idle_detect,
  input logic              char_timeout
);
  p_activity_clears_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_sample) |=> !idle_detect);

  p_activity_clears_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_sample) |=> !char_timeout);

  p_empty_blocks_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nempty |=> !char_timeout);

  p_read_clears_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_read |=> !char_timeout);

  p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_timeout) |-> $past(bit_tick));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(idle_detect) || (word_len != $past(word_len))));

  p_idle_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_detect && !(bit_tick && !rx_sample)) |=> (idle_detect || (word_len != $past(word_len))));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r8: assert (!idle_detect && !char_timeout);
    end
  end
endmodule

bind rxto_idle_timer rxto_idle_timer_chk #(.P_WL_W(P_WL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick    (bit_tick),
  .rx_sample   (rx_sample),
  .word_len    (word_len),
  .fifo_nempty (fifo_nempty),
  .rhr_read    (rhr_read),
  .idle_detect (idle_detect),
  .char_timeout(char_timeout)
);

// File: tb/rxto_idle_timer_test.sv
module rxto_idle_timer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       rx_sample = 1'b1;
  logic [1:0] word_len = 2'd0;
  logic       fifo_nempty = 1'b0;
  logic       rhr_read = 1'b0;
  logic       idle_detect;
  logic       char_timeout;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int sleep_m = 0;
  int to_m = 0;
  string phase = "R8";

  rxto_idle_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .rx_sample   (rx_sample),
    .word_len    (word_len),
    .fifo_nempty (fifo_nempty),
    .rhr_read    (rhr_read),
    .idle_detect (idle_detect),
    .char_timeout(char_timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int limit_of(input logic [1:0] wl);
    return 4 * (5 + int'(wl)) + 12;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_m = 0;
      to_m = 0;
    end else begin
      int lim;
      bit act;
      lim = limit_of(word_len);
      act = bit_tick && !rx_sample;
      if (act) sleep_m = 0;
      else if (bit_tick && sleep_m < lim) sleep_m++;
      if (act || rhr_read || !fifo_nempty) to_m = 0;
      else if (bit_tick && to_m < lim) to_m++;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(phase, idle_detect, sleep_m >= limit_of(word_len), "idle_detect vs model");
      check(phase, char_timeout, to_m >= limit_of(word_len), "char_timeout vs model");
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive(input logic t, input logic rx, input logic ne, input logic rd);
    @(negedge clk);
    bit_tick = t; rx_sample = rx; fifo_nempty = ne; rhr_read = rd;
  endtask

  // n high strobes, each followed by a quiet cycle
  task automatic high_ticks(input int n, input logic ne);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b1, ne, 1'b0);
      drive(1'b0, 1'b1, ne, 1'b0);
    end
  endtask

  task automatic settle(input logic ne);
    drive(1'b0, 1'b1, ne, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    phase = "R8";
    repeat (3) @(negedge clk);
    check("R8", idle_detect, 1'b0, "idle in reset");
    check("R8", char_timeout, 1'b0, "timeout in reset");
    rst_n = 1'b1;

    for (int w = 0; w < 4; w++) begin
      int lim;
      word_len = w[1:0];
      lim = limit_of(word_len);
      phase = "R3";
      drive(1'b1, 1'b0, 1'b1, 1'b0);
      settle(1'b1);
      check("R3", idle_detect, 1'b0, "idle after low sample");
      check("R9", char_timeout, 1'b0, "timeout after low sample");
      phase = "R1";
      high_ticks(lim - 1, 1'b1);
      settle(1'b1);
      check("R1", idle_detect, 1'b0, "idle one strobe short");
      check("R6", char_timeout, 1'b0, "timeout one strobe short");
      phase = "R6";
      high_ticks(1, 1'b1);
      settle(1'b1);
      check("R1", idle_detect, 1'b1, "idle at limit");
      check("R6", char_timeout, 1'b1, "timeout at limit");
    end

    phase = "R7";
    high_ticks(70, 1'b1);
    settle(1'b1);
    check("R7", idle_detect, 1'b1, "idle saturated");
    check("R7", char_timeout, 1'b1, "timeout saturated");

    phase = "R2";
    repeat (20) drive(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R2", idle_detect, 1'b1, "no strobe, low line ignored");

    phase = "R3";
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    settle(1'b1);
    check("R3", idle_detect, 1'b0, "low sample clears idle");

    // read collides with strobe one short of limit
    phase = "R5";
    word_len = 2'd0;
    high_ticks(31, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    settle(1'b1);
    check("R5", char_timeout, 1'b0, "read beats strobe");
    check("R1", idle_detect, 1'b1, "idle counts through read");
    high_ticks(31, 1'b1);
    settle(1'b1);
    check("R5", char_timeout, 1'b0, "restart needs full span");
    high_ticks(1, 1'b1);
    settle(1'b1);
    check("R6", char_timeout, 1'b1, "timeout after fresh span");

    phase = "R4";
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    settle(1'b0);
    check("R4", char_timeout, 1'b0, "empty fifo clears timeout");
    high_ticks(50, 1'b0);
    settle(1'b0);
    check("R4", char_timeout, 1'b0, "empty fifo holds zero");
    check("R1", idle_detect, 1'b1, "idle independent of fifo");

    // partway collision then mixed random traffic
    phase = "R5";
    high_ticks(10, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    settle(1'b1);
    check("R5", char_timeout, 1'b0, "read mid count");
    phase = "R2";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 40, r > 1, r > 3, r == 50);
      if (k % 500 == 0) word_len = 2'($urandom_range(0, 3));
    end
    settle(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule